// File: doc/BRIEF.md
# Power-On Strap Capture and Frequency Code Selector

This block sits beside the pads of a clock generator whose configuration pins double as clock outputs. While power-on reset is active, and for a fixed number of reference cycles after it is released, the shared pins are left undriven so that the board's pull resistors set their levels. At the end of that window the block latches the six strap levels: a 3-bit frequency code, a desktop/mobile mode flag, the SDRAM clock source and the CPU buffer voltage flag. One cycle later it turns the shared pins into outputs.

After capture the block supplies the effective frequency code. When the override flag in configuration register 0 is clear, the code is the strapped one. When the flag is set, the code is taken from the register's own 3-bit field. The register clears to zero, so the strapped code applies after power-up. The block also decodes the mode strap into the role of the two mode-dependent pins: extra SDRAM clock outputs in desktop mode, or CPU and PCI stop inputs in mobile mode. It gates the register's spread-spectrum controls so that they take effect only once capture is complete.

Top module: `strap_select_top`

## Requirements
- R1: While rst_n is low, and for the first HOLD_CYCLES-1 rising edges after it is released, strap_done is 0 and pad_oe is all zeros.
- R2: On the HOLD_CYCLES-th rising edge after release, the block samples pad_in and strap_done goes to 1. The pad_in bits are: bits 2:0 the frequency code, bit 3 the mode (1 = desktop), bit 4 the SDRAM source (1 = CPU frequency, 0 = AGP frequency) and bit 5 the CPU buffer flag (1 = 2.5 V).
- R3: pad_oe becomes all ones on the rising edge that follows capture. It is never nonzero while strap_done is 0.
- R4: Once captured, desktop_mode, sdram_from_cpu, cpu_low_volt and the strapped frequency code ignore every later change of pad_in until the next reset.
- R5: freq_code equals cfg_reg[6:4] when cfg_reg[3] is 1. Otherwise it equals the captured code from pad_in[2:0]. freq_code is 0 before capture.
- R6: In desktop mode, dual_oe is 2'b11 from the same edge as pad_oe and stop_in_active is 0. In mobile mode, dual_oe is 2'b00 and stop_in_active is 1 from capture onward. dual_oe and stop_in_active are never active together.
- R7: sdram_from_cpu reflects captured bit 4 and cpu_low_volt reflects captured bit 5. Both are 0 before capture.
- R8: After capture, spread_en follows cfg_reg[1], spread_down follows cfg_reg[2] and spread_wide follows cfg_reg[7]. Before capture all three are 0.
- R9: A new reset clears the captured state, and the following release repeats the whole sequence with the current pad_in levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| pad_in | input | 6 | Levels seen on the shared strap pins |
| cfg_reg | input | 7 | Configuration register 0, bits 7:1 |
| pad_oe | output | 6 | Drive enable for the shared strap pins |
| strap_done | output | 1 | Straps captured |
| freq_code | output | 3 | Effective frequency code |
| desktop_mode | output | 1 | Captured mode, 1 = desktop |
| sdram_from_cpu | output | 1 | SDRAM clock follows the CPU frequency |
| cpu_low_volt | output | 1 | CPU buffers set for 2.5 V |
| dual_oe | output | 2 | Drive enable of the two mode-dependent pins |
| stop_in_active | output | 1 | Mode-dependent pins act as stop inputs |
| spread_en | output | 1 | Spread-spectrum enable |
| spread_down | output | 1 | 1 = down spread, 0 = center spread |
| spread_wide | output | 1 | 1 = larger spread amount |

## Verification
The bound checker checks the following on every cycle:
- no pin is driven before capture;
- the pins switch to outputs exactly one cycle after capture;
- the captured straps and the unoverridden code stay stable;
- the two pin roles are exclusive;
- the spread controls are gated before capture.

Only the bench scenarios can show the rest:
- that capture lands on the exact HOLD_CYCLES-th edge;
- that each of the 64 strap patterns maps to the right outputs;
- that the override selects every register code;
- that a second reset recaptures changed levels.

// File: rtl/strap_pkg.sv
// Package: shared strap layout and register bit positions.
// Assumes pad_in bit order fixed by the board wiring described in the brief.
package strap_pkg;
    localparam int FS_W = 3;
    localparam int STRAP_W = 6;
    localparam int CFG_LO = 1;
    localparam int CFG_HI = 7;

    // Register 0 bit positions (decoded by neighbouring logic, so kept fixed).
    localparam int B_SPREAD_EN = 1;
    localparam int B_SPREAD_DOWN = 2;
    localparam int B_OVERRIDE = 3;
    localparam int B_CODE_LO = 4;
    localparam int B_SPREAD_WIDE = 7;

    // Captured strap word; packed MSB first maps to pad_in[5:0].
    typedef struct packed {
        logic            cpu_lv;
        logic            sd_cpu;
        logic            desktop;
        logic [FS_W-1:0] fs;
    } strap_t;
endpackage

// File: rtl/strap_capture.sv
// strap_capture: counts HOLD_CYCLES reference cycles after reset release,
// latches the strap levels once, then enables the pin drivers a cycle later.
// Assumes pad_in is stable around the capture edge (set by board resistors).
module strap_capture
    import strap_pkg::*;
#(
    parameter int HOLD_CYCLES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] pad_in,
    output strap_t             straps,
    output logic               done,
    output logic               oe
);
    localparam int CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // Hold counter, one-shot latch and driver enable sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            done   <= 1'b0;
            oe     <= 1'b0;
            straps <= '0;
        end else begin
            oe <= done;
            if (!done) begin
                if (cnt == LAST) begin
                    straps <= strap_t'(pad_in);
                    done   <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/freq_select.sv
// freq_select: chooses the frequency code between straps and register, and
// gates the spread controls until capture. Purely combinational.
module freq_select
    import strap_pkg::*;
(
    input  logic              done,
    input  logic [FS_W-1:0]   strap_fs,
    input  logic [CFG_HI:CFG_LO] cfg,
    output logic [FS_W-1:0]   code,
    output logic              sp_en,
    output logic              sp_down,
    output logic              sp_wide
);
    // Source selection for the frequency code.
    always_comb begin
        if (done && cfg[B_OVERRIDE])
            code = cfg[B_CODE_LO +: FS_W];
        else
            code = strap_fs;
    end

    // Spread controls become effective only after capture.
    always_comb begin
        sp_en   = done & cfg[B_SPREAD_EN];
        sp_down = done & cfg[B_SPREAD_DOWN];
        sp_wide = done & cfg[B_SPREAD_WIDE];
    end
endmodule

// File: rtl/pin_role.sv
// pin_role: decodes the mode strap into the role of the mode-dependent pins.
// Assumes desktop is valid once done is set.
module pin_role #(
    parameter int DUAL_W = 2
) (
    input  logic              done,
    input  logic              oe,
    input  logic              desktop,
    output logic [DUAL_W-1:0] dual_oe,
    output logic              stop_in
);
    // Desktop drives them as clocks; mobile listens to them as stop inputs.
    always_comb begin
        dual_oe = {DUAL_W{oe & desktop}};
        stop_in = done & ~desktop;
    end
endmodule

// File: rtl/strap_select_top.sv
// strap_select_top: power-on strap capture, pin handover and frequency code
// selection. Assumes cfg_reg is held at zero by its owner during reset.
module strap_select_top
    import strap_pkg::*;
#(
    parameter int HOLD_CYCLES = 8,
    parameter int DUAL_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [STRAP_W-1:0]   pad_in,
    input  logic [CFG_HI:CFG_LO] cfg_reg,
    output logic [STRAP_W-1:0]   pad_oe,
    output logic                 strap_done,
    output logic [FS_W-1:0]      freq_code,
    output logic                 desktop_mode,
    output logic                 sdram_from_cpu,
    output logic                 cpu_low_volt,
    output logic [DUAL_W-1:0]    dual_oe,
    output logic                 stop_in_active,
    output logic                 spread_en,
    output logic                 spread_down,
    output logic                 spread_wide
);
    strap_t straps;
    logic   oe;

    strap_capture #(.HOLD_CYCLES(HOLD_CYCLES)) u_cap (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in),
        .straps(straps), .done(strap_done), .oe(oe)
    );

    freq_select u_sel (
        .done(strap_done), .strap_fs(straps.fs), .cfg(cfg_reg),
        .code(freq_code), .sp_en(spread_en), .sp_down(spread_down),
        .sp_wide(spread_wide)
    );

    pin_role #(.DUAL_W(DUAL_W)) u_role (
        .done(strap_done), .oe(oe), .desktop(straps.desktop),
        .dual_oe(dual_oe), .stop_in(stop_in_active)
    );

    // Fan the captured fields and driver enable out to the ports.
    always_comb begin
        pad_oe         = {STRAP_W{oe}};
        desktop_mode   = straps.desktop;
        sdram_from_cpu = straps.sd_cpu;
        cpu_low_volt   = straps.cpu_lv;
    end
endmodule

// File: rtl/strap_select_chk.sv
// strap_select_chk: temporal checks on strap_select_top, attached by bind.
module strap_select_chk
    import strap_pkg::*;
#(
    parameter int DUAL_W = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [CFG_HI:CFG_LO] cfg_reg,
    input logic [STRAP_W-1:0]   pad_oe,
    input logic                 strap_done,
    input logic [FS_W-1:0]      freq_code,
    input logic                 desktop_mode,
    input logic                 sdram_from_cpu,
    input logic                 cpu_low_volt,
    input logic [DUAL_W-1:0]    dual_oe,
    input logic                 stop_in_active,
    input logic                 spread_en,
    input logic                 spread_down,
    input logic                 spread_wide
);
    assert_no_drive_early_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !strap_done |-> (pad_oe == '0 && dual_oe == '0));

    assert_drive_after_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strap_done) |=> (&pad_oe));

    assert_straps_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_done && $past(strap_done)) |->
        $stable({desktop_mode, sdram_from_cpu, cpu_low_volt}));

    assert_code_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_done && $past(strap_done) && !cfg_reg[B_OVERRIDE] && !$past(cfg_reg[B_OVERRIDE]))
        |-> $stable(freq_code));

    assert_roles_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !((|dual_oe) && stop_in_active));

    assert_spread_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !strap_done |-> !(spread_en || spread_down || spread_wide));
endmodule

bind strap_select_top strap_select_chk #(.DUAL_W(DUAL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_reg(cfg_reg), .pad_oe(pad_oe),
    .strap_done(strap_done), .freq_code(freq_code), .desktop_mode(desktop_mode),
    .sdram_from_cpu(sdram_from_cpu), .cpu_low_volt(cpu_low_volt),
    .dual_oe(dual_oe), .stop_in_active(stop_in_active), .spread_en(spread_en),
    .spread_down(spread_down), .spread_wide(spread_wide)
);

// File: tb/sim_strap_select_top.sv
// sim_strap_select_top: sweeps all strap patterns and all override codes.
module sim_strap_select_top;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] pad_in = '0;
    logic [7:1] cfg_reg = '0;
    logic [5:0] pad_oe;
    logic       strap_done;
    logic [2:0] freq_code;
    logic       desktop_mode, sdram_from_cpu, cpu_low_volt;
    logic [1:0] dual_oe;
    logic       stop_in_active, spread_en, spread_down, spread_wide;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    strap_select_top #(.HOLD_CYCLES(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .cfg_reg(cfg_reg),
        .pad_oe(pad_oe), .strap_done(strap_done), .freq_code(freq_code),
        .desktop_mode(desktop_mode), .sdram_from_cpu(sdram_from_cpu),
        .cpu_low_volt(cpu_low_volt), .dual_oe(dual_oe),
        .stop_in_active(stop_in_active), .spread_en(spread_en),
        .spread_down(spread_down), .spread_wide(spread_wide)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Reset, hold pad_in = v with cfg all ones, and check the sequence.
    task automatic run_strap(input logic [5:0] v);
        @(negedge clk);
        rst_n = 1'b0; pad_in = v; cfg_reg = 7'h7F;
        repeat (2) @(negedge clk);
        check("R1 reset done", strap_done, 0);
        check("R1 reset oe", pad_oe, 0);
        check("R7 reset sdram", sdram_from_cpu, 0);
        check("R5 reset code", freq_code, 0);
        rst_n = 1'b1;
        for (int i = 1; i < HOLD; i++) begin
            @(negedge clk);
            check("R1 hold done", strap_done, 0);
            check("R1 hold oe", pad_oe, 0);
            check("R8 gated", {spread_wide, spread_down, spread_en}, 0);
        end
        @(negedge clk);
        check("R2 done", strap_done, 1);
        check("R3 oe at capture", pad_oe, 0);
        check("R6 dual at capture", dual_oe, 0);
        check("R6 stop", stop_in_active, !v[3]);
        check("R2 mode", desktop_mode, v[3]);
        check("R7 sdram src", sdram_from_cpu, v[4]);
        check("R7 cpu volt", cpu_low_volt, v[5]);
        check("R5 override code", freq_code, 7);
        check("R8 spread on", {spread_wide, spread_down, spread_en}, 7);
        cfg_reg = 7'h00;
        #1;
        check("R5 strap code", freq_code, v[2:0]);
        check("R8 spread off", {spread_wide, spread_down, spread_en}, 0);
        @(negedge clk);
        check("R3 oe after", pad_oe, 6'h3F);
        check("R6 dual after", dual_oe, v[3] ? 2'b11 : 2'b00);
        pad_in = ~v;
        repeat (2) @(negedge clk);
        check("R4 frozen fields", {cpu_low_volt, sdram_from_cpu, desktop_mode}, v[5:3]);
        check("R4 frozen code", freq_code, v[2:0]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R2 R9: every strap pattern, each with a fresh reset.
        for (int v = 0; v < 64; v++) run_strap(6'(v));

        // R5 R8: override sweep against two strap codes.
        for (int s = 0; s < 2; s++) begin
            logic [5:0] sv;
            sv = s ? 6'b010110 : 6'b101001;
            run_strap(sv);
            for (int ov = 0; ov < 2; ov++)
                for (int c = 0; c < 8; c++)
                    for (int sp = 0; sp < 8; sp++) begin
                        @(negedge clk);
                        cfg_reg = {sp[2], c[2:0], ov[0], sp[1], sp[0]};
                        #1;
                        check("R5 select", freq_code, ov ? c : int'(sv[2:0]));
                        check("R8 spread", {spread_wide, spread_down, spread_en}, sp);
                    end
        end

        // R9: reset in mid-operation recaptures changed levels.
        run_strap(6'b001011);
        run_strap(6'b110100);
        finish_run();
    end
endmodule